// File: doc/BRIEF.md
# Byte-Lane Table Lookup Unit

This block translates a 32-bit word one byte at a time through a small lookup table. The table holds up to 32 bytes and arrives as four 64-bit words packed into one 256-bit input. A 32-bit index word carries four 8-bit indices, one for each output byte. A 5-bit limit sets how much of the table is live.

Each lane compares its index with the limit on its own. An index at or below the limit picks the addressed table byte. An index above the limit leaves that lane of the supplied destination word unchanged. This lets a wider lookup be built from several passes, where each pass fills only the lanes it covers.

The lookup itself is combinational. A parameter selects either a registered output, which appears one cycle after the input strobe, or a purely combinational output.

Top module: `byte_lane_lookup`

## Requirements
- R1: Lane k of the result, at bits 8k+7:8k, is driven only by the index in bits 8k+7:8k of `idxWord`, so lane 0 uses bits 7:0.
- R2: A lane whose index is less than or equal to `maxIdx` outputs the table byte at that index.
- R3: A lane whose index is greater than `maxIdx` outputs the same lane of `dstWord`.
- R4: In an index, bits 4:3 select table word w, which is `tableWords[64w+63:64w]`. Bits 2:0 select byte b inside that word, with byte 0 being its least significant byte.
- R5: An index equal to `maxIdx` is in range. An index of `maxIdx`+1 passes the destination byte through.
- R6: An index of 32 or more always passes the destination byte through, whatever the limit is.
- R7: The four lanes are resolved independently, so a mix of in-range and out-of-range lanes is allowed in one word.
- R8: With the registered option, `outValid` is high exactly in the cycle after a cycle with `inValid` high, and `outWord` then holds the result for the inputs sampled with that strobe.
- R9: After reset, `outValid` is 0 and `outWord` is 0.
- R10: With the registered option, `outWord` keeps its value through any cycle in which `inValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input strobe; the inputs are sampled when it is high |
| tableWords | input | 256 | Four 64-bit table words; word w is at bits 64w+63:64w |
| idxWord | input | 32 | Four 8-bit lane indices |
| dstWord | input | 32 | Existing destination word, used for lanes whose index is out of range |
| maxIdx | input | 5 | Largest index that is still in range |
| outValid | output | 1 | Result strobe |
| outWord | output | 32 | Looked-up result |

## Verification
Wrong internal state in this block shows up as a wrong byte in one lane, one cycle after the strobe. The most likely cause is a faulty lane compare or byte select. An off-by-one limit compare only shows at the boundary index. Random table contents make a wrong word or byte select visible in the very next result. Directed indices at the limit, at the limit plus one, and at 32 and above target the compare. A missing or stale load enable shows as a changed output during idle cycles, or as a strobe that is one cycle early or late.

// File: rtl/lookup_pkg.sv
package lookup_pkg;
  typedef struct packed {
    logic loadEn;
    logic validNext;
  } ctrl_strobe_t;
endpackage

// File: rtl/lookup_lane.sv
module lookup_lane #(
  parameter int LANE_W   = 8,
  parameter int TBL_REGS = 4,
  parameter int REG_W    = 64,
  parameter int IDX_W    = 5
) (
  input  logic [TBL_REGS*REG_W-1:0] tableWords,
  input  logic [LANE_W-1:0]         laneIdx,
  input  logic [LANE_W-1:0]         dstByte,
  input  logic [IDX_W-1:0]          maxIdx,
  output logic [LANE_W-1:0]         laneOut
);
  localparam int BYTES_PER_REG = REG_W / LANE_W;
  localparam int BYTE_SEL_W    = $clog2(BYTES_PER_REG);
  localparam int REG_SEL_W     = (TBL_REGS > 1) ? $clog2(TBL_REGS) : 1;

  logic [REG_SEL_W-1:0]  regSel;
  logic [BYTE_SEL_W-1:0] byteSel;
  logic [REG_W-1:0]      selReg;
  logic [LANE_W-1:0]     selByte;
  logic                  inRange;

  assign byteSel = laneIdx[BYTE_SEL_W-1:0];
  assign regSel  = REG_SEL_W'(laneIdx >> BYTE_SEL_W);
  assign inRange = laneIdx <= {{(LANE_W-IDX_W){1'b0}}, maxIdx};

  always_comb begin
    selReg = '0;
    for (int r = 0; r < TBL_REGS; r++) begin
      if (regSel == REG_SEL_W'(r)) selReg = tableWords[r*REG_W +: REG_W];
    end
  end

  always_comb begin
    selByte = '0;
    for (int b = 0; b < BYTES_PER_REG; b++) begin
      if (byteSel == BYTE_SEL_W'(b)) selByte = selReg[b*LANE_W +: LANE_W];
    end
  end

  assign laneOut = inRange ? selByte : dstByte;
endmodule

// File: rtl/lookup_datapath.sv
module lookup_datapath
  import lookup_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int TBL_REGS   = 4,
  parameter int REG_W      = 64,
  parameter int IDX_W      = 5,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobe_t              strobes,
  input  logic [TBL_REGS*REG_W-1:0] tableWords,
  input  logic [LANES*LANE_W-1:0]   idxWord,
  input  logic [LANES*LANE_W-1:0]   dstWord,
  input  logic [IDX_W-1:0]          maxIdx,
  output logic [LANES*LANE_W-1:0]   resultWord
);
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] lookupWord;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    lookup_lane #(
      .LANE_W(LANE_W), .TBL_REGS(TBL_REGS), .REG_W(REG_W), .IDX_W(IDX_W)
    ) u_lane (
      .tableWords(tableWords),
      .laneIdx   (idxWord[l*LANE_W +: LANE_W]),
      .dstByte   (dstWord[l*LANE_W +: LANE_W]),
      .maxIdx    (maxIdx),
      .laneOut   (lookupWord[l*LANE_W +: LANE_W])
    );
  end

  if (REGISTERED) begin : g_reg
    logic [WORD_W-1:0] heldWord;
    always_ff @(posedge clk) begin
      if (!rstN) heldWord <= '0;
      else if (strobes.loadEn) heldWord <= lookupWord;
    end
    assign resultWord = heldWord;
  end else begin : g_comb
    assign resultWord = lookupWord;
  end
endmodule

// File: rtl/lookup_ctrl.sv
module lookup_ctrl
  import lookup_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrl_strobe_t strobes,
  output logic         outValid
);
  assign strobes.loadEn    = inValid;
  assign strobes.validNext = inValid;

  if (REGISTERED) begin : g_reg
    logic validQ;
    always_ff @(posedge clk) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= strobes.validNext;
    end
    assign outValid = validQ;
  end else begin : g_comb
    assign outValid = strobes.validNext;
  end
endmodule

// File: rtl/byte_lane_lookup.sv
module byte_lane_lookup
  import lookup_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int TBL_REGS   = 4,
  parameter int REG_W      = 64,
  parameter bit REGISTERED = 1'b1,
  localparam int IDX_W     = $clog2(TBL_REGS * REG_W / LANE_W),
  localparam int WORD_W    = LANES * LANE_W,
  localparam int TBL_W     = TBL_REGS * REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [TBL_W-1:0]  tableWords,
  input  logic [WORD_W-1:0] idxWord,
  input  logic [WORD_W-1:0] dstWord,
  input  logic [IDX_W-1:0]  maxIdx,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord
);
  ctrl_strobe_t strobes;

  lookup_ctrl #(.REGISTERED(REGISTERED)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  lookup_datapath #(
    .LANES(LANES), .LANE_W(LANE_W), .TBL_REGS(TBL_REGS), .REG_W(REG_W),
    .IDX_W(IDX_W), .REGISTERED(REGISTERED)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .tableWords(tableWords),
    .idxWord   (idxWord),
    .dstWord   (dstWord),
    .maxIdx    (maxIdx),
    .resultWord(outWord)
  );
endmodule

// File: rtl/byte_lane_lookup_chk.sv
module byte_lane_lookup_chk #(
  parameter int TBL_W      = 256,
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 5,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [TBL_W-1:0]  tableWords,
  input logic [WORD_W-1:0] idxWord,
  input logic [WORD_W-1:0] dstWord,
  input logic [IDX_W-1:0]  maxIdx,
  input logic              outValid,
  input logic [WORD_W-1:0] outWord
);
  logic [7:0] lane0Ref;
  logic       lane0In;
  assign lane0In  = idxWord[7:0] <= {3'b000, maxIdx};
  assign lane0Ref = tableWords[{idxWord[4:0], 3'b000} +: 8];

  if (REGISTERED) begin : g_props
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> $stable(outWord));
    // R3: lane 0 out of range passes the destination byte
    a_r3_lane0_pass: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !lane0In) |=> outWord[7:0] == $past(dstWord[7:0]));
    // R2: lane 0 in range takes the table byte
    a_r2_lane0_table: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && lane0In) |=> outWord[7:0] == $past(lane0Ref));
  end
endmodule

bind byte_lane_lookup byte_lane_lookup_chk #(
  .TBL_W(TBL_W), .WORD_W(WORD_W), .IDX_W(IDX_W), .REGISTERED(REGISTERED)
) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .tableWords(tableWords),
  .idxWord(idxWord), .dstWord(dstWord), .maxIdx(maxIdx),
  .outValid(outValid), .outWord(outWord)
);

// File: tb/byte_lane_lookup_tb.sv
`timescale 1ns/1ps
module byte_lane_lookup_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [255:0] tableWords = '0;
  logic [31:0]  idxWord = '0;
  logic [31:0]  dstWord = '0;
  logic [4:0]   maxIdx = '0;
  logic         outValid;
  logic [31:0]  outWord;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  byte_lane_lookup u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .tableWords(tableWords),
    .idxWord(idxWord), .dstWord(dstWord), .maxIdx(maxIdx),
    .outValid(outValid), .outWord(outWord)
  );

  function automatic logic [31:0] expWord(logic [255:0] t, logic [31:0] ix,
                                          logic [31:0] d, logic [4:0] mx);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) begin
      logic [7:0] i;
      logic [63:0] w;
      i = ix[l*8 +: 8];
      if (i <= {3'b000, mx}) begin
        w = t[int'(i[4:3])*64 +: 64];
        r[l*8 +: 8] = w[int'(i[2:0])*8 +: 8];
      end else begin
        r[l*8 +: 8] = d[l*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] randTable();
    logic [255:0] t;
    for (int k = 0; k < 8; k++) t[k*32 +: 32] = $urandom;
    return t;
  endfunction

  task automatic send(string req, logic [255:0] t, logic [31:0] ix,
                      logic [31:0] d, logic [4:0] mx);
    tableWords = t; idxWord = ix; dstWord = d; maxIdx = mx; inValid = 1'b1;
    @(negedge clk);
    check({req, " R8 valid"}, {31'b0, outValid}, 32'd1);
    check(req, outWord, expWord(t, ix, d, mx));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [255:0] t;
    logic [31:0] held;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R9 reset valid", {31'b0, outValid}, 32'd0);
    check("R9 reset word", outWord, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {31'b0, outValid}, 32'd0);

    // R4: known table, byte k holds value k+0x40
    for (int k = 0; k < 32; k++) t[k*8 +: 8] = 8'(k + 8'h40);
    send("R4 R1 lanes 0,9,18,31", t, 32'h1F_12_09_00, 32'hAABBCCDD, 5'd31);
    check("R4 explicit", outWord, 32'h5F_52_49_40);
    send("R2 R5 at limit", t, 32'h0F_0F_0F_0F, 32'h11223344, 5'd15);
    check("R5 limit explicit", outWord, 32'h4F4F4F4F);
    send("R3 R5 limit+1", t, 32'h10_10_10_10, 32'h11223344, 5'd15);
    check("R5 plus one explicit", outWord, 32'h11223344);
    send("R6 big index", t, 32'hFF_80_20_21, 32'hCAFEF00D, 5'd31);
    check("R6 explicit", outWord, 32'hCAFEF00D);
    send("R7 mixed lanes", t, 32'h08_30_07_40, 32'h99887766, 5'd7);
    check("R7 explicit", outWord, 32'h99_88_47_66);

    // R10: idle cycle holds the output while inputs change
    held = outWord;
    inValid = 1'b0; idxWord = 32'h0; dstWord = 32'h0; tableWords = '1;
    @(negedge clk);
    check("R8 valid low", {31'b0, outValid}, 32'd0);
    check("R10 hold", outWord, held);
    @(negedge clk);
    check("R10 hold 2", outWord, held);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] ix;
      logic [4:0] mx;
      for (int l = 0; l < 4; l++)
        ix[l*8 +: 8] = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 40);
      mx = ($urandom % 2 == 0) ? 5'(($urandom % 4) * 8 + 7) : 5'($urandom);
      send("R2 R3 random", randTable(), ix, $urandom, mx);
      if (n % 37 == 0) begin
        held = outWord;
        inValid = 1'b0; dstWord = $urandom; tableWords = randTable();
        @(negedge clk);
        check("R10 random hold", outWord, held);
        check("R8 random valid low", {31'b0, outValid}, 32'd0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule